// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is an I2C slave that places a small on-chip byte memory on a two-wire bus. It samples SCL and SDA with the system clock and drives SDA only by pulling it low through an output enable. It finds START and STOP conditions and receives a slave address. If that address selects the device, it takes an array offset and then writes single bytes or bursts within a 16-byte page, or it returns bytes in address order until the master declines one.

A density parameter sets the memory to 1, 2, 4 or 8 blocks of 256 bytes. The three chip-select bits of the slave address are split by that parameter. The low bits select a block inside the device, and the remaining upper bits must equal the strapped pins. An internal address pointer survives between transfers, so a read that carries no offset continues from where the previous access stopped.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, and at any time the device is not addressed, `sda_oe` is 0 (SDA released).
- R2: The slave address is received MSB first. Bits 7:4 are the device type and must equal 4'b1010. Bits 3:1 are the chip-select field. Bit 0 is the direction: 1 for a read, 0 for a write. The device acknowledges, by holding `sda_oe` at 1 throughout the 9th SCL high period, only when the type matches and the pin comparison of R3 passes.
- R3: With BLOCKS = 2^k, the low k bits of the chip-select field (address bits k:1) select the 256-byte block. The upper 3-k bits must equal `addr_pins` at the same positions. With the default of 2 blocks, bits 3:2 are compared with `addr_pins[2:1]`, and bit 1 selects the block.
- R4: In a write, the byte that follows the acknowledged slave address is acknowledged, and it sets the pointer to (block << 8) | byte.
- R5: Each further data byte in a write is acknowledged and stored at the pointer.
- R6: After each stored byte, only the low 4 pointer bits advance, wrapping from 15 to 0. The upper bits stay fixed, so a burst never leaves its 16-byte aligned page.
- R7: In a read, the device sends each byte MSB first, with `sda_oe` equal to the inverse of the data bit. `sda_oe` changes only while SCL is low.
- R8: A read returns successive bytes, and the pointer advances by one across the whole memory, crossing block boundaries and wrapping at the end. A master acknowledge (SDA low in the 9th clock) asks for the next byte. A master NACK ends the read and releases SDA.
- R9: A read started without a new offset uses the stored pointer, with its block bits replaced by the block selected in the new slave address.
- R10: A START at any point, including in the middle of a byte, restarts reception of the slave address from bit 7. A STOP returns the device to idle.
- R11: After a slave address that does not match, the device acknowledges nothing and writes nothing until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| addr_pins | input | 3 | Strapped chip-select pins |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions rely on the bus being slow compared with the system clock. Each SCL level must last longer than the synchronizer plus edge-detect delay. The master may move SDA while SCL is high only to form a START or a STOP. Under these conditions every SCL edge is seen exactly once, and the output enable can only change in a low phase. The stimulus holds each half-period of SCL for six system clocks or more, and it changes the master's SDA only in low phases, except in the START and STOP tasks.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEVSEL,
      PH_OFFSET,
      PH_WRITE,
      PH_READ
   } phase_t;

   localparam int BYTE_W  = 8;
   localparam int BLK_SZ  = 256;
   localparam int CS_W    = 3;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_d, sda_d;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_ee_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_d  <= scl_sh[STAGES-1];
         sda_d  <= sda_sh[STAGES-1];
      end
   end

   assign scl_lvl   = scl_sh[STAGES-1];
   assign sda_lvl   = sda_sh[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
   parameter int AW    = 9,
   parameter int DW    = 8,
   parameter int DEPTH = 512
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] cells [DEPTH];

   if (DEPTH > (1 << AW)) begin : g_bad_depth
      $error("i2c_ee_mem: DEPTH exceeds address range");
   end

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];
endmodule

// File: rtl/i2c_ee_match.sv
module i2c_ee_match #(
   parameter int         BLOCKS   = 2,
   parameter logic [3:0] DEV_TYPE = 4'b1010,
   localparam int        BLK_BITS = $clog2(BLOCKS),
   localparam int        BLK_W    = (BLK_BITS == 0) ? 1 : BLK_BITS
) (
   input  logic [7:0]       dev_byte,
   input  logic [2:0]       pins,
   output logic             hit,
   output logic [BLK_W-1:0] blk
);
   localparam logic [2:0] PIN_MASK = 3'(3'b111 << BLK_BITS);

   logic pin_ok;

   assign pin_ok = (((dev_byte[3:1] ^ pins) & PIN_MASK) == 3'b000);
   assign hit    = (dev_byte[7:4] == DEV_TYPE) && pin_ok;

   if (BLK_BITS == 0) begin : g_single_block
      assign blk = '0;
   end else begin : g_block_select
      assign blk = dev_byte[BLK_BITS:1];
   end
endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
   import i2c_ee_pkg::*;
#(
   parameter int         BLOCKS     = 2,
   parameter logic [3:0] DEV_TYPE   = 4'b1010,
   parameter int         PAGE_BYTES = 16,
   localparam int        BLK_BITS   = $clog2(BLOCKS),
   localparam int        BLK_W      = (BLK_BITS == 0) ? 1 : BLK_BITS,
   localparam int        ADDR_W     = 8 + BLK_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [2:0]        pins,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              sda_oe
);
   localparam int              PG_BITS = $clog2(PAGE_BYTES);
   localparam logic [ADDR_W-1:0] PG_MASK = ADDR_W'(PAGE_BYTES - 1);

   phase_t            ph;
   logic [3:0]        bitcnt;
   logic [7:0]        shreg, txreg;
   logic [ADDR_W-1:0] ptr;
   logic              rw_q, mack;
   logic [BLK_W-1:0]  blk_q, blk;
   logic              hit;
   logic [2:0]        tx_idx;

   i2c_ee_match #(.BLOCKS(BLOCKS), .DEV_TYPE(DEV_TYPE)) u_match (
      .dev_byte (shreg),
      .pins     (pins),
      .hit      (hit),
      .blk      (blk)
   );

   function automatic logic [ADDR_W-1:0] compose(input logic [BLK_W-1:0] b,
                                                 input logic [7:0] low);
      return (ADDR_W'(b) << 8) | ADDR_W'(low);
   endfunction

   function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
      return (a & ~PG_MASK) | ((a + ADDR_W'(1)) & PG_MASK);
   endfunction

   assign tx_idx    = 3'(4'd7 - bitcnt);
   assign mem_addr  = ptr;
   assign mem_wdata = shreg;
   assign mem_we    = scl_fall && (bitcnt == 4'd8) && (ph == PH_WRITE)
                      && !start_det && !stop_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         bitcnt <= '0;
         shreg  <= '0;
         txreg  <= '0;
         ptr    <= '0;
         rw_q   <= 1'b0;
         mack   <= 1'b0;
         blk_q  <= '0;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         ph     <= PH_DEVSEL;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else if (stop_det) begin
         ph     <= PH_IDLE;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else if (ph != PH_IDLE) begin
         if (scl_rise) begin
            if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_lvl};
            else if (bitcnt == 4'd8) mack <= ~sda_lvl;
            if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
         end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
               unique case (ph)
                  PH_DEVSEL: begin
                     if (hit) begin
                        sda_oe <= 1'b1;
                        rw_q   <= shreg[0];
                        blk_q  <= blk;
                        if (shreg[0]) ptr <= compose(blk, ptr[7:0]);
                     end else begin
                        ph     <= PH_IDLE;
                        bitcnt <= '0;
                     end
                  end
                  PH_OFFSET: begin
                     sda_oe <= 1'b1;
                     ptr    <= compose(blk_q, shreg);
                  end
                  PH_WRITE: begin
                     sda_oe <= 1'b1;
                     ptr    <= page_next(ptr);
                  end
                  PH_READ: begin
                     sda_oe <= 1'b0;
                     ptr    <= ptr + ADDR_W'(1);
                  end
                  default: ;
               endcase
            end else if (bitcnt == 4'd9) begin
               bitcnt <= '0;
               sda_oe <= 1'b0;
               unique case (ph)
                  PH_DEVSEL: begin
                     if (rw_q) begin
                        ph     <= PH_READ;
                        txreg  <= mem_rdata;
                        sda_oe <= ~mem_rdata[7];
                     end else begin
                        ph <= PH_OFFSET;
                     end
                  end
                  PH_OFFSET: ph <= PH_WRITE;
                  PH_READ: begin
                     if (mack) begin
                        txreg  <= mem_rdata;
                        sda_oe <= ~mem_rdata[7];
                     end else begin
                        ph <= PH_IDLE;
                     end
                  end
                  default: ;
               endcase
            end else if (ph == PH_READ && bitcnt != 4'd0) begin
               sda_oe <= ~txreg[tx_idx];
            end
         end
      end
   end

   // R10: the bit counter never leaves the 9-clock frame
   assert_bitcnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= 4'd9);

   // R11: an idle device never pulls SDA
   assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE) |-> !sda_oe);

   // R6: back-to-back data bytes keep the page bits of the pointer
   assert_page_stay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_WRITE && $past(ph) == PH_WRITE)
      |-> (ptr[ADDR_W-1:PG_BITS] == $past(ptr[ADDR_W-1:PG_BITS])));

   // R2: an address acknowledge follows a matching slave address
   assert_ack_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) && ph == PH_DEVSEL) |-> $past(hit));
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
   parameter int         BLOCKS      = 2,
   parameter logic [3:0] DEV_TYPE    = 4'b1010,
   parameter int         PAGE_BYTES  = 16,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] addr_pins,
   output logic       sda_oe
);
   localparam int BLK_BITS = $clog2(BLOCKS);
   localparam int ADDR_W   = 8 + BLK_BITS;
   localparam int DEPTH    = BLOCKS * i2c_ee_pkg::BLK_SZ;

   if (!(BLOCKS == 1 || BLOCKS == 2 || BLOCKS == 4 || BLOCKS == 8)) begin : g_bad_blocks
      $error("i2c_eeprom_slave: BLOCKS must be 1, 2, 4 or 8");
   end
   if (PAGE_BYTES < 2 || PAGE_BYTES > 256 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("i2c_eeprom_slave: PAGE_BYTES must be a power of two from 2 to 256");
   end

   logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_wdata, mem_rdata;

   i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_ee_ctrl #(
      .BLOCKS     (BLOCKS),
      .DEV_TYPE   (DEV_TYPE),
      .PAGE_BYTES (PAGE_BYTES)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .pins      (addr_pins),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .sda_oe    (sda_oe)
   );

   i2c_ee_mem #(.AW(ADDR_W), .DW(8), .DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .addr  (mem_addr),
      .wdata (mem_wdata),
      .rdata (mem_rdata)
   );

   // R7: the device only starts pulling SDA during an SCL low phase
   assert_oe_in_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !$past(scl_lvl));

   // R5: memory is written only on a falling SCL edge
   assert_write_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (!scl_lvl && $past(scl_lvl)));
endmodule

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
   localparam int Q = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] pins = 3'b101;
   logic       sda_oe;
   logic       sda_bus;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_eeprom_slave dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl),
      .sda_i     (sda_bus),
      .addr_pins (pins),
      .sda_oe    (sda_oe)
   );

   always #2 clk = ~clk;

   int         checks = 0;
   int         fails = 0;
   logic       chk_en = 1'b0;
   logic       exp_oe = 1'b0;
   string      cur_req = "R1";
   logic [7:0] ref_mem [512];
   int         ref_ptr = 0;

   // reference comparison on every clock of an SCL high window
   always @(posedge clk) begin
      #1;
      if (chk_en) begin
         checks++;
         if (sda_oe !== exp_oe) begin
            fails++;
            $display("FAIL %s: sda_oe=%0b expected %0b at %0t", cur_req, sda_oe, exp_oe, $time);
         end
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_cycle(input logic mbit, input logic eo);
      @(negedge clk);
      sda_m = mbit;
      wait_n(Q);
      scl = 1'b1;
      wait_n(2);
      exp_oe = eo;
      chk_en = 1'b1;
      wait_n(Q - 2);
      chk_en = 1'b0;
      scl = 1'b0;
      wait_n(2);
   endtask

   task automatic do_start();
      @(negedge clk);
      sda_m = 1'b1;
      wait_n(Q);
      scl = 1'b1;
      wait_n(Q);
      sda_m = 1'b0;
      wait_n(Q);
      scl = 1'b0;
      wait_n(2);
   endtask

   task automatic do_stop();
      @(negedge clk);
      sda_m = 1'b0;
      wait_n(Q);
      scl = 1'b1;
      wait_n(Q);
      sda_m = 1'b1;
      wait_n(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic ack);
      for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b0);
      bit_cycle(1'b1, ack);
   endtask

   task automatic recv_byte(input logic [7:0] expv, input logic give_ack);
      for (int i = 7; i >= 0; i--) bit_cycle(1'b1, ~expv[i]);
      bit_cycle(~give_ack, 1'b0);
   endtask

   function automatic logic [7:0] dev(input int blk, input logic rw);
      return {4'b1010, pins[2:1], blk[0], rw};
   endfunction

   task automatic write_txn(input int blk, input logic [7:0] a, input int n,
                            input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2);
      logic [7:0] lo;
      logic [7:0] dv [3];
      dv[0] = d0; dv[1] = d1; dv[2] = d2;
      lo = a;
      do_start();
      cur_req = "R2";
      send_byte(dev(blk, 1'b0), 1'b1);
      cur_req = "R4";
      send_byte(a, 1'b1);
      for (int k = 0; k < n; k++) begin
         cur_req = (k == 0) ? "R5" : "R6";
         send_byte(dv[k], 1'b1);
         ref_mem[blk * 256 + int'(lo)] = dv[k];
         lo = (lo & 8'hF0) | ((lo + 8'd1) & 8'h0F);
      end
      ref_ptr = blk * 256 + int'(lo);
      do_stop();
   endtask

   task automatic read_cur(input int blk, input int n, input string req);
      do_start();
      cur_req = "R2";
      send_byte(dev(blk, 1'b1), 1'b1);
      ref_ptr = blk * 256 + (ref_ptr % 256);
      cur_req = req;
      for (int k = 0; k < n; k++) begin
         recv_byte(ref_mem[ref_ptr], k < n - 1);
         ref_ptr = (ref_ptr + 1) % 512;
      end
      do_stop();
   endtask

   task automatic rand_read(input int blk, input logic [7:0] a, input int n,
                            input string req);
      do_start();
      cur_req = "R2";
      send_byte(dev(blk, 1'b0), 1'b1);
      cur_req = "R4";
      send_byte(a, 1'b1);
      ref_ptr = blk * 256 + int'(a);
      read_cur(blk, n, req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      wait_n(5);
      rst_n = 1'b1;
      wait_n(3);
      // R1: released after reset
      checks++;
      if (sda_oe !== 1'b0) begin
         fails++;
         $display("FAIL R1: sda_oe=%0b expected 0 after reset", sda_oe);
      end

      // R6: burst from 0xFE wraps to 0xF0 inside its page
      write_txn(0, 8'hFE, 3, 8'h11, 8'h22, 8'h33);
      write_txn(1, 8'h00, 2, 8'h77, 8'h88, 8'h00);
      write_txn(0, 8'h02, 1, 8'h99, 8'h00, 8'h00);
      write_txn(1, 8'h05, 1, 8'h3C, 8'h00, 8'h00);
      write_txn(0, 8'h05, 1, 8'hA5, 8'h00, 8'h00);

      // R3: block bit picks between the two 0x05 cells
      rand_read(1, 8'h05, 1, "R3");
      rand_read(0, 8'h05, 1, "R3");
      rand_read(0, 8'hF0, 1, "R6");

      // R8: sequential read crosses from block 0 into block 1
      rand_read(0, 8'hFF, 2, "R8");
      // R9: current-address read with block 1, then with block 0
      read_cur(1, 1, "R9");
      read_cur(0, 1, "R9");

      // R2: wrong device type is not acknowledged; R11: traffic ignored
      do_start();
      cur_req = "R2";
      send_byte(8'b1011_1000, 1'b0);
      cur_req = "R11";
      send_byte(8'h05, 1'b0);
      send_byte(8'h00, 1'b0);
      do_stop();
      // R3: pin mismatch is not acknowledged
      do_start();
      cur_req = "R3";
      send_byte(8'b1010_0100, 1'b0);
      cur_req = "R11";
      send_byte(8'h05, 1'b0);
      send_byte(8'h00, 1'b0);
      do_stop();
      rand_read(0, 8'h05, 1, "R11");

      // R10: START in the middle of a byte restarts the address phase
      do_start();
      cur_req = "R10";
      bit_cycle(1'b1, 1'b0);
      bit_cycle(1'b0, 1'b0);
      bit_cycle(1'b1, 1'b0);
      write_txn(1, 8'h05, 1, 8'h5A, 8'h00, 8'h00);
      rand_read(1, 8'h05, 1, "R10");
      // R7: a multi-byte read with mixed bit patterns
      rand_read(1, 8'h00, 2, "R7");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule